// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Register Memory

This block is a target (slave) on a two-wire I2C bus that gives a controller access to a 256-byte on-chip register memory. It watches the clock and data lines, recognises START and STOP, collects an address byte and responds only when the upper seven bits equal its own device address. The block never drives the data line high. It asserts an output-enable that pulls the line low, so the line is open-drain.

A write transfer always begins with a byte that sets an internal word pointer. Every later byte in that transfer is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the current pointer. The pointer advances after each byte, and the block keeps sending until the controller declines to acknowledge.

The pointer survives a repeated START. A controller can therefore set the pointer in a short write and then read from that location in the same bus session. Both bus lines are resynchronised to the system clock, which must run at least eight times faster than the bus clock.

Top module: `i2c_ptr_ram_target`

## Requirements
- R1: A falling data line while the clock is high (START) starts collection of a new address byte. A rising data line while the clock is high (STOP) returns the block to idle with the data line released.
- R2: The address byte arrives MSB first. Its upper seven bits are compared with `DEV_ADDR`, and bit 0 selects the direction (1 = read, 0 = write). On a match the block holds the data line low for exactly the ninth bit period as acknowledge.
- R3: On an address mismatch the block never pulls the data line low until the next START.
- R4: In a write transfer, the first byte after the address is acknowledged and loads the word pointer. It is not stored in memory.
- R5: Every later write byte is acknowledged, stored at the pointer, and followed by a pointer increment.
- R6: In a read transfer the block sends the byte at the pointer MSB first over eight bit periods, and then increments the pointer. The pointer value is kept for the next transfer.
- R7: After each sent byte the block releases the data line during the ninth bit. A low acknowledge leads to the next byte. A high one (NACK) ends the transfer, and the line stays released until the next START.
- R8: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R9: A repeated START keeps the pointer. A write that sets the pointer, followed by a repeated START and a read, returns the byte at that pointer.
- R10: The block asserts its pull-down only while the bus clock is low.
- R11: Reset clears every memory byte to zero, releases the data line and puts the block in idle.
- R12: A bit counts only after a clock rise followed by a fall. The clock fall that follows START is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A corrupt state in the bit engine shows up on the bus within one byte. The acknowledge can appear on the wrong bit or fail to appear, read data can come out shifted by one place, or the line can be held low across a STOP. A wrong word pointer only becomes visible at the next read. For that reason every store is read back through a fresh pointer-set, repeated START and read, and the expected data comes from a model of the memory kept by the bench. Releases after a NACK and after a foreign address are watched continuously, so a stray pull-down during those windows is caught in the same bit period.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } i2cr_state_e;
endpackage

// File: rtl/i2cr_bus_sync.sv
module i2cr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus level is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Data edges during a stable high clock are bus conditions.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_mem.sv
module i2cr_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          mem_we,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] mem_wdata,
  output logic          sda_oe,
  output i2cr_state_e   state
);
  localparam int          CNT_W    = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  i2cr_state_e      state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    rx_q, rx_d, rx_next;
  logic [DW-1:0]    tx_q, tx_d;
  logic [AW-1:0]    ptr_d;
  logic             pend_q, pend_d;
  logic             rw_q, rw_d;
  logic             in_bit_q, in_bit_d;
  logic             oe_d;

  assign rx_next   = {rx_q[DW-2:0], sda_s};
  assign mem_wdata = rx_next;

  always_comb begin
    state_d  = state;
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    ptr_d    = ptr;
    pend_d   = pend_q;
    rw_d     = rw_q;
    in_bit_d = in_bit_q;
    oe_d     = sda_oe;
    mem_we   = 1'b0;

    if (start_det) begin
      state_d  = ST_ADDR;
      cnt_d    = '0;
      in_bit_d = 1'b0;
      oe_d     = 1'b0;
      pend_d   = 1'b1;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      in_bit_d = 1'b0;
      oe_d     = 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        in_bit_d = 1'b1;
      end else if (scl_fall && in_bit_q) begin
        in_bit_d = 1'b0;
        unique case (state)
          ST_ADDR: begin
            rx_d  = rx_next;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (rx_next[DW-1:1] == DEV_ADDR) begin
                rw_d    = rx_next[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_RD_ACK: begin
            cnt_d = '0;
            if ((state == ST_ADDR_ACK && rw_q) || (state == ST_RD_ACK && !sda_s)) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
              ptr_d   = ptr + 1'b1;
              state_d = ST_RD_BYTE;
            end else if (state == ST_ADDR_ACK) begin
              oe_d    = 1'b0;
              state_d = ST_WR_BYTE;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
          ST_WR_BYTE: begin
            rx_d  = rx_next;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
              if (pend_q) begin
                ptr_d  = rx_next[AW-1:0];
                pend_d = 1'b0;
              end else begin
                mem_we = 1'b1;
                ptr_d  = ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR_BYTE;
          end
          ST_RD_BYTE: begin
            cnt_d = cnt_q + 1'b1;
            tx_d  = tx_q << 1;
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              oe_d = ~tx_q[DW-2];
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr      <= '0;
      pend_q   <= 1'b0;
      rw_q     <= 1'b0;
      in_bit_q <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      state    <= state_d;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      ptr      <= ptr_d;
      pend_q   <= pend_d;
      rw_q     <= rw_d;
      in_bit_q <= in_bit_d;
      sda_oe   <= oe_d;
    end
  end
endmodule

// File: rtl/i2c_ptr_ram_target.sv
module i2c_ptr_ram_target
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         PTR_W       = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] mem_wdata, rd_data;
  i2cr_state_e       state;

  i2cr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cr_mem #(.AW(PTR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  i2cr_ctrl #(.AW(PTR_W), .DW(DATA_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .mem_we(mem_we), .ptr(ptr), .mem_wdata(mem_wdata),
    .sda_oe(sda_oe), .state(state)
  );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
  import i2cr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_det,
  input logic        stop_det,
  input logic        mem_we,
  input logic        sda_oe,
  input i2cr_state_e state
);
  // R1: START leads to address collection
  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && !sda_oe);

  // R1: STOP leads to idle with line released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_oe);

  // R2: pull-down held throughout the address acknowledge bit
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> sda_oe);

  // R3: idle (mismatch or after NACK) never drives the line
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5: a store is followed by its acknowledge bit
  p_store_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (state == ST_WR_ACK) && sda_oe);

  // R10: pull-down is never newly applied while the clock is high
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_ptr_ram_target i2cr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .mem_we(mem_we), .sda_oe(sda_oe), .state(state)
);

// File: tb/sim_i2c_ptr_ram_target.sv
module sim_i2c_ptr_ram_target;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [7:0] AW_ = {DEV, 1'b0};
  localparam logic [7:0] AR_ = {DEV, 1'b1};
  localparam int H = 10;
  // {pointer, data} pairs written then read back
  localparam logic [15:0] VEC [6] = '{16'h10A5, 16'h113C, 16'h7F01,
                                       16'h80FE, 16'h0055, 16'hC7C3};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_drv, sda_drv, sda_bus;
  logic sda_oe;
  assign sda_bus = sda_drv & ~sda_oe;

  i2c_ptr_ram_target #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_bad = 0, r10_viol = 0;
  logic oe_seen, oe_prev;
  logic [7:0] model [256];

  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (sda_oe === 1'b1) oe_seen <= 1'b1;
    if (rst_n && scl_drv && sda_oe && !oe_prev) r10_viol++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_bit(logic b, output logic s);
    sda_drv = b; hold(H);
    scl_drv = 1'b1; hold(H);
    s = sda_bus;
    scl_drv = 1'b0; hold(H);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hold(H);
    scl_drv = 1'b1; hold(H);
    sda_drv = 1'b0; hold(H);
    scl_drv = 1'b0; hold(H);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hold(H);
    scl_drv = 1'b1; hold(H);
    sda_drv = 1'b1; hold(H);
  endtask

  task automatic send(logic [7:0] v, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) put_bit(v[i], d);
    put_bit(1'b1, ack);
  endtask

  task automatic recv(logic give_ack, output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) put_bit(1'b1, v[i]);
    put_bit(!give_ack, d);
  endtask

  task automatic set_ptr(logic [7:0] p, string tag);
    logic a;
    i2c_start(); send(AW_, a); check({tag, " addr ack"}, {7'd0, a}, 8'd0);
    send(p, a); check({tag, " ptr ack"}, {7'd0, a}, 8'd0);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; oe_seen = 1'b0;
    hold(5);
    check("R11 oe in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1; hold(5);

    // R11 memory zero after reset; R2/R12 address acknowledge position
    set_ptr(8'h20, "R2 R12");
    i2c_start(); send(AR_, a); check("R2 R12 read addr ack", {7'd0, a}, 8'd0);
    recv(1'b0, b); check("R11 reset content", b, 8'h00);
    i2c_stop(); hold(4);
    check("R1 released after STOP", {7'd0, sda_oe}, 8'd0);

    // Table walk: write one byte, read it back via repeated START (R5 R9)
    for (int k = 0; k < 6; k++) begin
      set_ptr(VEC[k][15:8], "R5");
      send(VEC[k][7:0], a); check("R5 data ack", {7'd0, a}, 8'd0);
      model[VEC[k][15:8]] = VEC[k][7:0];
      i2c_stop();
      set_ptr(VEC[k][15:8], "R9");
      i2c_start(); send(AR_, a);
      recv(1'b0, b); check("R9 readback", b, model[VEC[k][15:8]]);
      i2c_stop();
    end

    // Burst write and burst read (R5 R6 R7)
    set_ptr(8'h40, "R5 burst");
    for (int i = 0; i < 4; i++) begin
      send(8'h11 * (i + 1), a); check("R5 burst ack", {7'd0, a}, 8'd0);
      model[8'h40 + i] = 8'h11 * (i + 1);
    end
    i2c_stop();
    set_ptr(8'h40, "R6");
    i2c_start(); send(AR_, a);
    for (int i = 0; i < 4; i++) begin
      recv(i < 3, b); check("R6 R7 burst read", b, model[8'h40 + i]);
    end
    i2c_stop();

    // Pointer kept after read: next read continues at 0x44 (R6); then NACK release (R7)
    i2c_start(); send(AR_, a); recv(1'b0, b);
    check("R6 pointer carried", b, model[8'h44]);
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) put_bit(1'b1, a);
    check("R7 released after NACK", {7'd0, oe_seen}, 8'd0);
    i2c_stop();

    // Foreign address (R3)
    i2c_start(); oe_seen = 1'b0;
    send({DEV ^ 7'h01, 1'b0}, a); check("R3 no ack", {7'd0, a}, 8'd1);
    send(8'h00, a);
    check("R3 line untouched", {7'd0, oe_seen}, 8'd0);
    i2c_stop();

    // Pointer byte is not stored (R4)
    set_ptr(8'h33, "R4"); i2c_stop();
    set_ptr(8'h33, "R4");
    i2c_start(); send(AR_, a); recv(1'b0, b);
    check("R4 pointer byte not stored", b, 8'h00);
    i2c_stop();

    // Wrap across 0xFF (R8)
    set_ptr(8'hFE, "R8");
    for (int i = 0; i < 3; i++) begin
      send(8'hA1 + i, a);
      model[8'(8'hFE + i)] = 8'hA1 + i;
    end
    i2c_stop();
    set_ptr(8'hFF, "R8");
    i2c_start(); send(AR_, a);
    recv(1'b1, b); check("R8 read at 0xFF", b, 8'hA2);
    recv(1'b0, b); check("R8 read wrapped 0x00", b, 8'hA3);
    i2c_stop();

    check("R10 pull-down only with clock low", 8'(r10_viol), 8'd0);

    // Reset clears memory (R11)
    hold(4); rst_n = 1'b0; hold(4); rst_n = 1'b1; hold(4);
    set_ptr(8'h40, "R11");
    i2c_start(); send(AR_, a); recv(1'b0, b);
    check("R11 cleared by reset", b, 8'h00);
    i2c_stop();

    summary();
  end
endmodule